// File: doc/BRIEF.md
# Dual-Rate Serial Timeslot Port with Bypass

This block frames one voice channel between two serial links and a parallel codec core. The sample link carries 8-bit words and the code link carries 4-bit words. Each link has its own bit clock and its own frame strobe, so the two links can run at different rates and put their words in different timeslots. A frame strobe that is sampled high on a rising bit-clock edge marks the first bit of a word. Every word is shifted most significant bit first. Each serial output comes as a data line and an enable line. The enable is high only while the block's own word is on the line, and low at all other times, so that other devices can share the wire.

Each received word crosses into the core clock domain through a toggle handshake with two-flop synchronisers. The core sees it as a parallel word with a one-cycle valid strobe. The words to transmit come from the core as levels that are held steady, and each serial side loads its word at its own frame strobe. If a received word is still waiting to cross and a newer word replaces it, the older word is dropped and the next word delivered carries an overrun flag. When the bypass control is high, the code link switches to 8-bit words. In that mode, a word received on one link is sent out unchanged on the other link at that link's next frame, which allows a timeslot to be moved from one position to another.

Top module: `tsp_chan_port`

## Requirements
- R1: After a sample-link frame strobe is sampled high, `pcm_so_oe` stays high for exactly 8 bit periods and then goes low. During those periods `pcm_so` carries `core_pcm_tx`, MSB in the first period.
- R2: With bypass off, after a code-link frame strobe `adp_so_oe` stays high for exactly 4 bit periods. During them `adp_so` carries `core_adp_tx`, MSB first. The enable is then low.
- R3: With bypass on, `adp_so_oe` stays high for 8 bit periods per frame instead of 4.
- R4: With bypass off, the 8 bits on `pcm_si` (first bit at the strobe edge, MSB first) reach the core as `core_pcm_rx`, with `core_pcm_vld` high for one core cycle.
- R5: With bypass off, the 4 bits on `adp_si` reach the core as `core_adp_rx`, with a one-cycle `core_adp_vld` and `core_adp_ovr` low.
- R6: With bypass on, an 8-bit word received on `adp_si` is sent unchanged on `pcm_so` at the next sample-link frame.
- R7: With bypass on, an 8-bit word received on `pcm_si` is sent unchanged on `adp_so` at the next code-link frame.
- R8: With bypass on, `core_pcm_vld` and `core_adp_vld` stay low.
- R9: When a code word replaces an earlier one that has not yet been sent across, the earlier word is never delivered. The replacing word is delivered with its ovr output high.
- R10: While `rst_n` is low, both output enables and both valid strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| core_clk | input | 1 | Codec core clock |
| thru_en | input | 1 | Bypass select, 1 = words pass between the links |
| pcm_bclk | input | 1 | Sample link bit clock |
| pcm_fs | input | 1 | Sample link frame strobe |
| pcm_si | input | 1 | Sample link serial data in |
| pcm_so | output | 1 | Sample link serial data out |
| pcm_so_oe | output | 1 | Sample link output enable |
| adp_bclk | input | 1 | Code link bit clock |
| adp_fs | input | 1 | Code link frame strobe |
| adp_si | input | 1 | Code link serial data in |
| adp_so | output | 1 | Code link serial data out |
| adp_so_oe | output | 1 | Code link output enable |
| core_pcm_tx | input | PCM_W | Sample word to transmit |
| core_adp_tx | input | ADP_W | Code word to transmit |
| core_pcm_rx | output | PCM_W | Received sample word |
| core_pcm_vld | output | 1 | Received sample word strobe |
| core_pcm_ovr | output | 1 | Overrun flag for the sample word |
| core_adp_rx | output | ADP_W | Received code word |
| core_adp_vld | output | 1 | Received code word strobe |
| core_adp_ovr | output | 1 | Overrun flag for the code word |

## Verification
The hardest case to reach is an overrun. In normal running the core clock is so much faster than either bit clock that the handshake always finishes before the next word arrives. The bench therefore stops the core clock and sends three code frames. The first word is launched and hangs mid-handshake, the second waits, and the third replaces it. When the core clock resumes, the bench expects exactly the first word with the flag low and then the third with the flag high. Bypass is the other hard case: the sample link and the code link are interleaved so that each output frame has to carry the word the other link received just before.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
   localparam int unsigned PCM_BITS    = 8;
   localparam int unsigned ADP_BITS    = 4;
   localparam int unsigned SYNC_STAGES = 2;

   function automatic int unsigned cnt_w(int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/tsp_sync.sv
module tsp_sync #(
   parameter int unsigned N = tsp_pkg::SYNC_STAGES,
   parameter int unsigned W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (N < 2) begin : g_bad_depth
         $error("tsp_sync: N must be at least 2");
      end
   endgenerate

   logic [N-1:0][W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= '0;
      else        st <= {st[N-2:0], d};
   end

   assign q = st[N-1];
endmodule

// File: rtl/tsp_ser_rx.sv
module tsp_ser_rx #(
   parameter int unsigned W  = tsp_pkg::PCM_BITS,
   parameter int unsigned CW = tsp_pkg::cnt_w(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fs_i,
   input  logic          sd_i,
   input  logic [CW-1:0] len_i,
   output logic [W-1:0]  word_o,
   output logic          stb_o
);
   logic [W-1:0]  sh;
   logic [CW-1:0] cnt;
   logic          last;

   assign last = (cnt != '0) && (cnt == len_i - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         cnt    <= '0;
         word_o <= '0;
         stb_o  <= 1'b0;
      end else begin
         stb_o <= 1'b0;
         if (fs_i) begin
            sh  <= W'(sd_i);
            cnt <= CW'(1);
         end else if (cnt != '0) begin
            sh <= {sh[W-2:0], sd_i};
            if (last) begin
               cnt    <= '0;
               stb_o  <= 1'b1;
               word_o <= {sh[W-2:0], sd_i};
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   AST_RX_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |=> !stb_o); // R4
endmodule

// File: rtl/tsp_ser_tx.sv
module tsp_ser_tx #(
   parameter int unsigned W  = tsp_pkg::PCM_BITS,
   parameter int unsigned CW = tsp_pkg::cnt_w(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fs_i,
   input  logic [CW-1:0] len_i,
   input  logic [W-1:0]  word_i,
   output logic          so_o,
   output logic          oe_o
);
   logic [W-1:0]  sh;
   logic [CW-1:0] rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         rem <= '0;
      end else if (fs_i) begin
         sh  <= word_i;
         rem <= len_i;
      end else if (rem != '0) begin
         sh  <= sh << 1;
         rem <= rem - 1'b1;
      end
   end

   assign so_o = sh[W-1];
   assign oe_o = (rem != '0);

   // checker: length of each enable run against the length latched at the strobe
   logic [CW-1:0] run;
   logic [CW-1:0] len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= '0;
         len_q <= '0;
      end else if (fs_i) begin
         run   <= CW'(1);
         len_q <= len_i;
      end else if (rem > CW'(1)) begin
         run <= run + 1'b1;
      end
   end

   AST_OE_AFTER_FS: assert property (@(posedge clk) disable iff (!rst_n)
      fs_i |=> oe_o); // R1
   AST_OE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_o) |-> (run == len_q)); // R2
endmodule

// File: rtl/tsp_word_cdc.sv
module tsp_word_cdc #(
   parameter int unsigned W = tsp_pkg::PCM_BITS,
   parameter int unsigned N = tsp_pkg::SYNC_STAGES
) (
   input  logic         rst_n,
   input  logic         src_clk,
   input  logic [W-1:0] src_word,
   input  logic         src_stb,
   input  logic         dst_clk,
   output logic [W-1:0] dst_word,
   output logic         dst_vld,
   output logic         dst_ovr
);
   logic [W-1:0] hold, lword;
   logic         fresh, hovr, lovr, req, ack_s, busy, launch;
   logic         rq_s, seen;

   tsp_sync #(.N(N), .W(1)) u_ack_sync (.clk(src_clk), .rst_n(rst_n), .d(seen), .q(ack_s));
   tsp_sync #(.N(N), .W(1)) u_req_sync (.clk(dst_clk), .rst_n(rst_n), .d(req),  .q(rq_s));

   assign busy   = req ^ ack_s;
   assign launch = fresh & ~busy;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         hold  <= '0;
         lword <= '0;
         fresh <= 1'b0;
         hovr  <= 1'b0;
         lovr  <= 1'b0;
         req   <= 1'b0;
      end else begin
         if (launch) begin
            lword <= hold;
            lovr  <= hovr;
            req   <= ~req;
         end
         if (src_stb) begin
            hold  <= src_word;
            fresh <= 1'b1;
            hovr  <= fresh & ~launch;
         end else if (launch) begin
            fresh <= 1'b0;
            hovr  <= 1'b0;
         end
      end
   end

   always_ff @(posedge dst_clk or negedge rst_n) begin
      if (!rst_n) begin
         seen     <= 1'b0;
         dst_word <= '0;
         dst_ovr  <= 1'b0;
         dst_vld  <= 1'b0;
      end else begin
         dst_vld <= 1'b0;
         if (rq_s != seen) begin
            seen     <= rq_s;
            dst_word <= lword;
            dst_ovr  <= lovr;
            dst_vld  <= 1'b1;
         end
      end
   end

   AST_LAUNCH_HELD: assert property (@(posedge src_clk) disable iff (!rst_n)
      busy |=> $stable({lovr, lword})); // R9
   AST_VLD_PULSE: assert property (@(posedge dst_clk) disable iff (!rst_n)
      dst_vld |=> !dst_vld); // R5
endmodule

// File: rtl/tsp_chan_port.sv
module tsp_chan_port #(
   parameter int unsigned PCM_W  = tsp_pkg::PCM_BITS,
   parameter int unsigned ADP_W  = tsp_pkg::ADP_BITS,
   parameter int unsigned SYNC_N = tsp_pkg::SYNC_STAGES
) (
   input  logic             rst_n,
   input  logic             core_clk,
   input  logic             thru_en,
   input  logic             pcm_bclk,
   input  logic             pcm_fs,
   input  logic             pcm_si,
   output logic             pcm_so,
   output logic             pcm_so_oe,
   input  logic             adp_bclk,
   input  logic             adp_fs,
   input  logic             adp_si,
   output logic             adp_so,
   output logic             adp_so_oe,
   input  logic [PCM_W-1:0] core_pcm_tx,
   input  logic [ADP_W-1:0] core_adp_tx,
   output logic [PCM_W-1:0] core_pcm_rx,
   output logic             core_pcm_vld,
   output logic             core_pcm_ovr,
   output logic [ADP_W-1:0] core_adp_rx,
   output logic             core_adp_vld,
   output logic             core_adp_ovr
);
   localparam int unsigned CW  = tsp_pkg::cnt_w(PCM_W);
   localparam int unsigned PAD = PCM_W - ADP_W;

   generate
      if (ADP_W < 2 || ADP_W >= PCM_W) begin : g_bad_width
         $error("tsp_chan_port: need 2 <= ADP_W < PCM_W");
      end
   endgenerate

   logic             adp_thru_s;
   logic [CW-1:0]    adp_len, pcm_len;
   logic [PCM_W-1:0] pcm_rx_word, adp_rx_word;
   logic             pcm_rx_stb, adp_rx_stb;
   logic [PCM_W-1:0] p_word, a_word, p_last, a_last, pcm_txq, adp_txq;
   logic             p_vld, p_ovr, a_vld, a_ovr;

   tsp_sync #(.N(SYNC_N), .W(1)) u_thru_sync (
      .clk(adp_bclk), .rst_n(rst_n), .d(thru_en), .q(adp_thru_s));

   assign pcm_len = CW'(PCM_W);
   assign adp_len = adp_thru_s ? CW'(PCM_W) : CW'(ADP_W);

   tsp_ser_rx #(.W(PCM_W), .CW(CW)) u_pcm_rx (
      .clk(pcm_bclk), .rst_n(rst_n), .fs_i(pcm_fs), .sd_i(pcm_si),
      .len_i(pcm_len), .word_o(pcm_rx_word), .stb_o(pcm_rx_stb));

   tsp_ser_rx #(.W(PCM_W), .CW(CW)) u_adp_rx (
      .clk(adp_bclk), .rst_n(rst_n), .fs_i(adp_fs), .sd_i(adp_si),
      .len_i(adp_len), .word_o(adp_rx_word), .stb_o(adp_rx_stb));

   tsp_word_cdc #(.W(PCM_W), .N(SYNC_N)) u_pcm_cdc (
      .rst_n(rst_n), .src_clk(pcm_bclk), .src_word(pcm_rx_word), .src_stb(pcm_rx_stb),
      .dst_clk(core_clk), .dst_word(p_word), .dst_vld(p_vld), .dst_ovr(p_ovr));

   tsp_word_cdc #(.W(PCM_W), .N(SYNC_N)) u_adp_cdc (
      .rst_n(rst_n), .src_clk(adp_bclk), .src_word(adp_rx_word), .src_stb(adp_rx_stb),
      .dst_clk(core_clk), .dst_word(a_word), .dst_vld(a_vld), .dst_ovr(a_ovr));

   always_ff @(posedge core_clk or negedge rst_n) begin
      if (!rst_n) begin
         p_last  <= '0;
         a_last  <= '0;
         pcm_txq <= '0;
         adp_txq <= '0;
      end else begin
         if (p_vld) p_last <= p_word;
         if (a_vld) a_last <= a_word;
         pcm_txq <= thru_en ? a_last : core_pcm_tx;
         adp_txq <= thru_en ? p_last : {core_adp_tx, {PAD{1'b0}}};
      end
   end

   tsp_ser_tx #(.W(PCM_W), .CW(CW)) u_pcm_tx (
      .clk(pcm_bclk), .rst_n(rst_n), .fs_i(pcm_fs), .len_i(pcm_len),
      .word_i(pcm_txq), .so_o(pcm_so), .oe_o(pcm_so_oe));

   tsp_ser_tx #(.W(PCM_W), .CW(CW)) u_adp_tx (
      .clk(adp_bclk), .rst_n(rst_n), .fs_i(adp_fs), .len_i(adp_len),
      .word_i(adp_txq), .so_o(adp_so), .oe_o(adp_so_oe));

   assign core_pcm_rx  = p_word;
   assign core_pcm_vld = p_vld & ~thru_en;
   assign core_pcm_ovr = p_ovr & ~thru_en;
   assign core_adp_rx  = a_word[ADP_W-1:0];
   assign core_adp_vld = a_vld & ~thru_en;
   assign core_adp_ovr = a_ovr & ~thru_en;
endmodule

// File: tb/tb_tsp_chan_port.sv
module tb_tsp_chan_port;
   logic core_clk = 0, core_run = 1, pcm_bclk = 0, adp_bclk = 0;
   logic rst_n = 0, thru_en = 0;
   logic pcm_fs = 0, pcm_si = 0, adp_fs = 0, adp_si = 0;
   logic [7:0] core_pcm_tx = 8'hA5;
   logic [3:0] core_adp_tx = 4'h9;
   logic pcm_so, pcm_so_oe, adp_so, adp_so_oe;
   logic [7:0] core_pcm_rx;
   logic [3:0] core_adp_rx;
   logic core_pcm_vld, core_pcm_ovr, core_adp_vld, core_adp_ovr;

   always #2  if (core_run) core_clk = ~core_clk;
   always #12 pcm_bclk = ~pcm_bclk;
   always #20 adp_bclk = ~adp_bclk;

   tsp_chan_port dut (.*);

   int n_chk = 0, n_bad = 0;
   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   logic [7:0] pexp, aexp, prx, arx, last_p = 0, last_a = 0;
   int prem = 0, arem = 0, prx_n = 0, arx_n = 0, thru_vld = 0;
   logic [8:0] pq[$], aq[$];
   bit a_auto = 1;

   always @(posedge pcm_bclk) if (rst_n) begin
      if (pcm_fs) begin pexp = thru_en ? last_a : core_pcm_tx; prem = 8; end
      else if (prem > 0) begin pexp = pexp << 1; prem--; end
      if (pcm_fs) begin prx = {7'b0, pcm_si}; prx_n = 1; end
      else if (prx_n > 0) begin prx = {prx[6:0], pcm_si}; prx_n++; end
      if (prx_n == 8) begin
         last_p = prx; prx_n = 0;
         if (!thru_en) pq.push_back({1'b0, prx});
      end
   end

   always @(posedge adp_bclk) if (rst_n) begin
      int len;
      len = thru_en ? 8 : 4;
      if (adp_fs) begin aexp = thru_en ? last_p : {core_adp_tx, 4'b0}; arem = len; end
      else if (arem > 0) begin aexp = aexp << 1; arem--; end
      if (adp_fs) begin arx = {7'b0, adp_si}; arx_n = 1; end
      else if (arx_n > 0) begin arx = {arx[6:0], adp_si}; arx_n++; end
      if (arx_n == len) begin
         last_a = arx; arx_n = 0;
         if (!thru_en && a_auto) aq.push_back({1'b0, arx});
      end
   end

   always @(negedge pcm_bclk) if (rst_n)
      check(pcm_so_oe == (prem > 0) && (prem == 0 || pcm_so == pexp[7]),
            thru_en ? "R6 pcm out" : "R1 pcm out", {pcm_so_oe, pcm_so},
            {(prem > 0), (prem > 0) ? pexp[7] : pcm_so});

   always @(negedge adp_bclk) if (rst_n)
      check(adp_so_oe == (arem > 0) && (arem == 0 || adp_so == aexp[7]),
            thru_en ? "R3 R7 adp out" : "R2 adp out", {adp_so_oe, adp_so},
            {(arem > 0), (arem > 0) ? aexp[7] : adp_so});

   always @(negedge core_clk) if (rst_n) begin
      logic [8:0] e;
      if (core_pcm_vld) begin
         if (thru_en) thru_vld++;
         else if (pq.size() == 0) check(0, "R4 unexpected word", core_pcm_rx, 0);
         else begin e = pq.pop_front(); check({core_pcm_ovr, core_pcm_rx} == e, "R4 rx word", {core_pcm_ovr, core_pcm_rx}, e); end
      end
      if (core_adp_vld) begin
         if (thru_en) thru_vld++;
         else if (aq.size() == 0) check(0, "R5 unexpected code", core_adp_rx, 0);
         else begin
            e = aq.pop_front();
            check({core_adp_ovr, 4'b0, core_adp_rx} == e, a_auto ? "R5 rx code" : "R9 overrun",
                  {core_adp_ovr, core_adp_rx}, e);
         end
      end
   end

   task automatic pcm_send(input logic [7:0] w, input int g);
      @(negedge pcm_bclk); pcm_fs = 1; pcm_si = w[7];
      for (int i = 6; i >= 0; i--) begin @(negedge pcm_bclk); pcm_fs = 0; pcm_si = w[i]; end
      if (g > 0) begin @(negedge pcm_bclk); pcm_si = 0; repeat (g - 1) @(negedge pcm_bclk); end
   endtask

   task automatic adp_send(input logic [7:0] w, input int n, input int g);
      @(negedge adp_bclk); adp_fs = 1; adp_si = w[n-1];
      for (int i = n - 2; i >= 0; i--) begin @(negedge adp_bclk); adp_fs = 0; adp_si = w[i]; end
      if (g > 0) begin @(negedge adp_bclk); adp_si = 0; repeat (g - 1) @(negedge adp_bclk); end
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #400000;
      check(0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      #50;
      check({pcm_so_oe, adp_so_oe, core_pcm_vld, core_adp_vld} == 4'b0, "R10 reset outputs",
            {pcm_so_oe, adp_so_oe, core_pcm_vld, core_adp_vld}, 0);
      #51 rst_n = 1;
      // normal mode, both links at once with different rates and gaps
      fork
         begin pcm_send(8'h3C, 2); pcm_send(8'h81, 0); pcm_send(8'hFF, 3); pcm_send(8'h00, 1); end
         begin adp_send(8'h06, 4, 1); adp_send(8'h00, 4, 0); adp_send(8'h0F, 4, 0); adp_send(8'h0A, 4, 2); end
      join
      repeat (4) @(negedge adp_bclk);
      core_pcm_tx = 8'h3E; core_adp_tx = 4'h4;
      repeat (2) @(negedge adp_bclk);
      fork
         pcm_send(8'h96, 3);
         adp_send(8'h05, 4, 3);
      join
      repeat (6) @(negedge adp_bclk);
      // bypass mode: words cross between the links
      thru_en = 1;
      repeat (6) @(negedge adp_bclk);
      adp_send(8'hC3, 8, 3);
      repeat (4) @(negedge pcm_bclk);
      pcm_send(8'h5A, 3);
      repeat (4) @(negedge adp_bclk);
      adp_send(8'h96, 8, 3);
      repeat (4) @(negedge pcm_bclk);
      pcm_send(8'hE1, 3);
      repeat (4) @(negedge adp_bclk);
      adp_send(8'h00, 8, 3);
      repeat (4) @(negedge pcm_bclk);
      pcm_send(8'h7F, 3);
      repeat (6) @(negedge adp_bclk);
      check(thru_vld == 0, "R8 no core strobe in bypass", thru_vld, 0);
      thru_en = 0;
      repeat (8) @(negedge adp_bclk);
      // overrun: core clock held while three code words arrive
      a_auto = 0;
      aq.push_back({1'b0, 8'h03});
      aq.push_back({1'b1, 8'h0C});
      core_run = 0;
      adp_send(8'h03, 4, 2);
      adp_send(8'h05, 4, 2);
      adp_send(8'h0C, 4, 2);
      repeat (4) @(negedge adp_bclk);
      core_run = 1;
      repeat (20) @(negedge adp_bclk);
      a_auto = 1;
      check(aq.size() == 0, "R9 words delivered", aq.size(), 0);
      adp_send(8'h0E, 4, 2);
      repeat (12) @(negedge adp_bclk);
      check(pq.size() == 0, "R4 all words delivered", pq.size(), 0);
      check(aq.size() == 0, "R5 all codes delivered", aq.size(), 0);
      summary();
   end
endmodule